// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 interrupt lines and turns them into two requests for a processor core. The first is a normal request, which is arbitrated by priority. The second is a fast request, which is reserved for line 0. Each line has its own configuration word. The word chooses between level and rising-edge detection and sets a 3-bit priority. Each line also has its own 32-bit handler address. Software programs the controller through a simple register-mapped slave port. Individual commands enable lines, disable lines, force a pending edge, remove a pending edge, and signal the end of a handler.

The handler reads the normal vector register, and that read acts as the acknowledge. At that moment the controller picks the winning line and returns its handler address. It also clears the winner's edge latch and records the line number. The winner's priority is pushed onto an in-service stack. From then on, a new normal request is raised only for a line whose priority is strictly higher than the top of the stack. An end-of-interrupt write pops the stack, so handlers can nest up to eight levels. When a vector read finds no qualifying line, it returns a programmable spurious value.

Top module: `prio_intc`

## Requirements
- R1: After reset, all of the following hold: the mask register reads 0, the pending register reads 0, the current-source register reads 0, `irq_o` and `fiq_o` are low, and the spurious value is 0x0000_0FFC.
- R2: A write to 0x120 sets every mask bit whose data bit is 1. A write to 0x124 clears every mask bit whose data bit is 1. Data bits that are 0 leave their mask bits unchanged. The resulting mask reads back at 0x110. A disabled line cannot raise a request.
- R3: A line configured for level mode is pending while its input is high, after a two-flop synchronizer. An enabled pending level line raises `irq_o` on the registered output.
- R4: A line configured for edge mode latches a rising edge and stays pending after its input falls. A write to 0x128 forces the latch of every edge-mode line whose data bit is 1. A write to 0x12C clears those latches. A forced set has no effect on a level-mode line.
- R5: Among enabled pending lines 1..31, the highest priority wins, and on a tie the lowest line number wins. A read of 0x100 returns the winner's vector word, which is located at 0x080 + 4*n. The line number of the winner then reads back at 0x108.
- R6: A read of 0x100 that finds a winner clears that winner's edge latch. It also pushes the winner's priority, so `irq_o` falls unless another line with a strictly higher priority is pending.
- R7: A line whose priority is strictly above the top of the in-service stack preempts, and a line of equal or lower priority does not. A write to 0x130 pops one level. Eight strictly rising levels can be nested.
- R8: Line 0 drives only `fiq_o`, and `fiq_o` is high when line 0 is both pending and enabled. Line 0 never wins normal arbitration. A read of 0x104 returns vector word 0 and clears line 0's edge latch.
- R9: A read of 0x100 or 0x104 that finds nothing qualifying returns the spurious register, which is written at 0x134, and has no side effect.
- R10: The pending register at 0x10C shows the raw pending state of every line, whether or not it is masked. The status register at 0x114 shows the normal request in bit 0 and the fast request in bit 1.
- R11: A configuration word at 0x000 + 4*n keeps the priority in bits [2:0] and edge mode in bit 4. On readback, all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Interrupt lines, asynchronous |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench checks that an equal-priority line does not preempt the handler in service. A design that compared with greater-or-equal would instead re-enter the same level without end. On a tie the bench expects the lower line number, and it then expects a spurious answer for the tied line until the end-of-interrupt. A design that scanned in the wrong direction, or did not push on acknowledge, would return the wrong vector. Other tests confirm that a level line keeps asserting after an acknowledge while an edge line's latch is gone. They also confirm that line 0 never reaches the normal path and that a forced set on a level line is ignored. Finally, the bench nests eight levels and unwinds them, which a stack built too shallow or with an off-by-one pointer would break.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int ADDR_W   = 12;
  localparam int EDGE_BIT = 4;

  localparam logic [ADDR_W-1:0] OFS_IRQV = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_FIQV = 12'h104;
  localparam logic [ADDR_W-1:0] OFS_CUR  = 12'h108;
  localparam logic [ADDR_W-1:0] OFS_PEND = 12'h10C;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h110;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h114;
  localparam logic [ADDR_W-1:0] OFS_EN   = 12'h120;
  localparam logic [ADDR_W-1:0] OFS_DIS  = 12'h124;
  localparam logic [ADDR_W-1:0] OFS_SETP = 12'h128;
  localparam logic [ADDR_W-1:0] OFS_CLRP = 12'h12C;
  localparam logic [ADDR_W-1:0] OFS_EOI  = 12'h130;
  localparam logic [ADDR_W-1:0] OFS_SPUR = 12'h134;
endpackage

// File: rtl/prio_intc_srcsync.sv
module prio_intc_srcsync #(
  parameter int N           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] edge_mode_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [SYNC_STAGES:0] shift_q;
    logic                 latch_q;
    logic                 synced;
    logic                 rise;

    always_ff @(posedge clk) begin
      if (rst) shift_q <= '0;
      else     shift_q <= {shift_q[SYNC_STAGES-1:0], src_i[g]};
    end

    assign synced = shift_q[SYNC_STAGES-1];
    assign rise   = synced & ~shift_q[SYNC_STAGES];

    // a fresh edge wins over an acknowledge or clear in the same cycle
    always_ff @(posedge clk) begin
      if (rst)                                latch_q <= 1'b0;
      else if ((rise | set_i[g]) & edge_mode_i[g]) latch_q <= 1'b1;
      else if (clr_i[g])                      latch_q <= 1'b0;
    end

    assign pend_o[g] = edge_mode_i[g] ? latch_q : synced;

    assert_clear_drops_latch_R6: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !set_i[g] && !(rise && edge_mode_i[g])) |=> !latch_q);
  end
endmodule

// File: rtl/prio_intc_arbiter.sv
module prio_intc_arbiter #(
  parameter int N  = 32,
  parameter int PW = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:1]          qual_i,
  input  logic [N-1:1][PW-1:0]  prio_i,
  input  logic                  cur_valid_i,
  input  logic [PW-1:0]         cur_lvl_i,
  output logic                  win_valid_o,
  output logic [IDX_W-1:0]      win_idx_o,
  output logic [PW-1:0]         win_prio_o
);
  logic             found;
  logic [PW-1:0]    best;
  logic [IDX_W-1:0] bidx;

  // scan from the top line down; ">=" lets a lower line take an equal level
  always_comb begin
    found = 1'b0;
    best  = '0;
    bidx  = '0;
    for (int i = N - 1; i >= 1; i--) begin
      if (qual_i[i] && (!found || prio_i[i] >= best)) begin
        found = 1'b1;
        best  = prio_i[i];
        bidx  = IDX_W'(i);
      end
    end
  end

  assign win_valid_o = found && (!cur_valid_i || best > cur_lvl_i);
  assign win_idx_o   = bidx;
  assign win_prio_o  = best;

  assert_winner_above_service_R7: assert property (@(posedge clk) disable iff (rst)
    (win_valid_o && cur_valid_i) |-> (win_prio_o > cur_lvl_i));
endmodule

// File: rtl/prio_intc_stack.sv
module prio_intc_stack #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  localparam int SP_W = $clog2(DEPTH + 1),
  localparam int IX_W = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [PW-1:0] push_val_i,
  output logic          nonempty_o,
  output logic [PW-1:0] top_o
);
  logic [PW-1:0]   stk [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] sp_m1;
  logic            full;

  assign full  = (sp_q == SP_W'(DEPTH));
  assign sp_m1 = sp_q - 1'b1;

  always_ff @(posedge clk) begin
    if (rst)                    sp_q <= '0;
    else if (push_i && !full)   sp_q <= sp_q + 1'b1;
    else if (pop_i && sp_q != 0) sp_q <= sp_m1;
  end

  always_ff @(posedge clk) begin
    if (push_i && !full) stk[sp_q[IX_W-1:0]] <= push_val_i;
  end

  assign nonempty_o = (sp_q != 0);
  assign top_o      = stk[sp_m1[IX_W-1:0]];

  assert_stack_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full);
  assert_push_strictly_rises_R7: assert property (@(posedge clk) disable iff (rst)
    (push_i && nonempty_o) |-> (push_val_i > top_o));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int          NUM_SRC     = 32,
  parameter int          PRIO_W      = 3,
  parameter int          STACK_DEPTH = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] SPUR_RST    = 32'h0000_0FFC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]             mask_q, edge_q, pend, qual;
  logic [NUM_SRC-1:0]             set_cmd, clr_cmd, ack_clr;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [31:0]                    vec_mem [NUM_SRC];
  logic [31:0]                    vec_q, reg_q, spur_q;
  logic                           use_vec_q;
  logic [IDX_W-1:0]               cur_src_q, reg_idx, vrd_idx;
  logic                           irq_q, fiq_q;

  logic wr_en, rd_en, in_mode, in_vec;
  logic irq_ack, fiq_ack, eoi;
  logic win_valid, stk_nonempty;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio, stk_top;

  // ---------------- decode ----------------
  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign in_mode = (bus_addr[ADDR_W-1:7] == '0);
  assign in_vec  = (bus_addr[ADDR_W-1:7] == 5'd1);
  assign reg_idx = bus_addr[IDX_W+1:2];

  assign qual    = pend & mask_q;
  assign irq_ack = rd_en && (bus_addr == OFS_IRQV) && win_valid;
  assign fiq_ack = rd_en && (bus_addr == OFS_FIQV) && qual[0];
  assign eoi     = wr_en && (bus_addr == OFS_EOI);

  assign set_cmd = (wr_en && bus_addr == OFS_SETP) ? bus_wdata[NUM_SRC-1:0] : '0;
  assign clr_cmd = (wr_en && bus_addr == OFS_CLRP) ? bus_wdata[NUM_SRC-1:0] : '0;

  always_comb begin
    ack_clr = '0;
    if (irq_ack) ack_clr[win_idx] = 1'b1;
    if (fiq_ack) ack_clr[0]       = 1'b1;
  end

  // ---------------- line conditioning ----------------
  prio_intc_srcsync #(.N(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .src_i       (src_i),
    .edge_mode_i (edge_q),
    .set_i       (set_cmd),
    .clr_i       (clr_cmd | ack_clr),
    .pend_o      (pend)
  );

  // ---------------- arbitration and nesting ----------------
  prio_intc_arbiter #(.N(NUM_SRC), .PW(PRIO_W)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .qual_i      (qual[NUM_SRC-1:1]),
    .prio_i      (prio_q[NUM_SRC-1:1]),
    .cur_valid_i (stk_nonempty),
    .cur_lvl_i   (stk_top),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_prio_o  (win_prio)
  );

  prio_intc_stack #(.DEPTH(STACK_DEPTH), .PW(PRIO_W)) u_stack (
    .clk        (clk),
    .rst        (rst),
    .push_i     (irq_ack),
    .pop_i      (eoi),
    .push_val_i (win_prio),
    .nonempty_o (stk_nonempty),
    .top_o      (stk_top)
  );

  // ---------------- configuration ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      edge_q <= '0;
      prio_q <= '0;
      spur_q <= SPUR_RST;
    end else if (wr_en) begin
      if (in_mode) begin
        prio_q[reg_idx] <= bus_wdata[PRIO_W-1:0];
        edge_q[reg_idx] <= bus_wdata[EDGE_BIT];
      end
      if (bus_addr == OFS_EN)   mask_q <= mask_q |  bus_wdata[NUM_SRC-1:0];
      if (bus_addr == OFS_DIS)  mask_q <= mask_q & ~bus_wdata[NUM_SRC-1:0];
      if (bus_addr == OFS_SPUR) spur_q <= bus_wdata;
    end
  end

  // vector words: one write port, one registered read port
  always_comb begin
    if (bus_addr == OFS_IRQV)      vrd_idx = win_idx;
    else if (bus_addr == OFS_FIQV) vrd_idx = '0;
    else                           vrd_idx = reg_idx;
  end

  always_ff @(posedge clk) begin
    if (wr_en && in_vec) vec_mem[reg_idx] <= bus_wdata;
    if (rd_en)           vec_q <= vec_mem[vrd_idx];
  end

  // ---------------- read side and acknowledge ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      use_vec_q <= 1'b0;
      cur_src_q <= '0;
    end else begin
      if (irq_ack)      cur_src_q <= win_idx;
      else if (fiq_ack) cur_src_q <= '0;
      if (rd_en) begin
        use_vec_q <= in_vec || irq_ack || fiq_ack;
        if (in_mode) reg_q <= (32'(edge_q[reg_idx]) << EDGE_BIT) | 32'(prio_q[reg_idx]);
        else begin
          case (bus_addr)
            OFS_IRQV, OFS_FIQV, OFS_SPUR: reg_q <= spur_q;
            OFS_CUR:  reg_q <= 32'(cur_src_q);
            OFS_PEND: reg_q <= 32'(pend);
            OFS_MASK: reg_q <= 32'(mask_q);
            OFS_STAT: reg_q <= {30'd0, fiq_q, irq_q};
            default:  reg_q <= '0;
          endcase
        end
      end
    end
  end

  assign bus_rdata = use_vec_q ? vec_q : reg_q;

  // ---------------- registered requests ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= win_valid;
      fiq_q <= qual[0];
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  assert_cur_src_follows_ack_R5: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> (cur_src_q == $past(win_idx)));
  assert_line0_not_normal_R8: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (win_idx != '0));
  assert_ack_needs_mask_R2: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> mask_q[win_idx]);
endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PIN = 2'd2, OP_SRC = 2'd3;
  localparam int NV = 56;
  localparam logic [31:0] SPUR = 32'h0000_0FFC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_i = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  prio_intc u_prio_intc (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] vec_of(input int n);
    return 32'hA000_0000 | (32'(n) << 4);
  endfunction

  // {op, addr, data-or-expected, requirement}
  localparam logic [49:0] TBL [0:NV-1] = '{
    {OP_RD,  12'h110, 32'h0,         4'd1},  // R1 mask clear
    {OP_RD,  12'h100, SPUR,          4'd9},  // R9 nothing pending
    {OP_PIN, 12'h000, 32'h0,         4'd1},  // R1 requests low
    {OP_RD,  12'h108, 32'h0,         4'd1},  // R1 current source
    {OP_WR,  12'h120, 32'h1E,        4'd2},  // R2 enable 1..4
    {OP_RD,  12'h110, 32'h1E,        4'd2},  // R2
    {OP_WR,  12'h124, 32'h10,        4'd2},  // R2 disable 4
    {OP_RD,  12'h110, 32'h0E,        4'd2},  // R2
    {OP_SRC, 12'h000, 32'h12,        4'd3},  // R3 lines 1 and 4 high
    {OP_PIN, 12'h000, 32'h1,         4'd3},  // R3
    {OP_RD,  12'h10C, 32'h12,        4'd10}, // R10 raw pending incl. masked
    {OP_RD,  12'h114, 32'h1,         4'd10}, // R10 status
    {OP_RD,  12'h100, 32'hA000_0010, 4'd5},  // R5 line 1 wins
    {OP_RD,  12'h108, 32'h1,         4'd5},  // R5
    {OP_PIN, 12'h000, 32'h0,         4'd6},  // R6 level held but not above
    {OP_SRC, 12'h000, 32'h16,        4'd4},  // R4 line 2 rising edge
    {OP_PIN, 12'h000, 32'h1,         4'd7},  // R7 preempts level 2
    {OP_RD,  12'h100, 32'hA000_0020, 4'd7},  // R7
    {OP_PIN, 12'h000, 32'h0,         4'd6},  // R6
    {OP_RD,  12'h10C, 32'h12,        4'd6},  // R6 edge latch cleared
    {OP_WR,  12'h128, 32'h08,        4'd4},  // R4 force line 3
    {OP_PIN, 12'h000, 32'h0,         4'd7},  // R7 equal level waits
    {OP_RD,  12'h10C, 32'h1A,        4'd4},  // R4
    {OP_WR,  12'h130, 32'h0,         4'd7},  // R7 end of interrupt
    {OP_PIN, 12'h000, 32'h1,         4'd7},  // R7
    {OP_RD,  12'h100, 32'hA000_0030, 4'd5},  // R5
    {OP_RD,  12'h108, 32'h3,         4'd5},  // R5
    {OP_WR,  12'h130, 32'h0,         4'd7},  // R7
    {OP_WR,  12'h130, 32'h0,         4'd7},  // R7
    {OP_PIN, 12'h000, 32'h1,         4'd3},  // R3 level line again
    {OP_WR,  12'h124, 32'h02,        4'd2},  // R2 disable 1
    {OP_PIN, 12'h000, 32'h0,         4'd2},  // R2
    {OP_RD,  12'h100, SPUR,          4'd9},  // R9
    {OP_WR,  12'h128, 32'h0C,        4'd4},  // R4 force 2 and 3
    {OP_RD,  12'h100, 32'hA000_0020, 4'd5},  // R5 tie: lower line
    {OP_RD,  12'h100, SPUR,          4'd7},  // R7 equal level blocked
    {OP_WR,  12'h130, 32'h0,         4'd7},  // R7
    {OP_RD,  12'h100, 32'hA000_0030, 4'd5},  // R5
    {OP_WR,  12'h130, 32'h0,         4'd7},  // R7
    {OP_WR,  12'h128, 32'h04,        4'd4},  // R4
    {OP_WR,  12'h12C, 32'h04,        4'd4},  // R4 clear removes it
    {OP_RD,  12'h10C, 32'h12,        4'd4},  // R4
    {OP_WR,  12'h128, 32'h20,        4'd4},  // R4 set on level line 5
    {OP_RD,  12'h10C, 32'h12,        4'd4},  // R4 ignored
    {OP_WR,  12'h120, 32'h01,        4'd8},  // R8 enable line 0
    {OP_SRC, 12'h000, 32'h17,        4'd8},  // R8 line 0 rises
    {OP_PIN, 12'h000, 32'h2,         4'd8},  // R8 fast only
    {OP_RD,  12'h114, 32'h2,         4'd10}, // R10
    {OP_RD,  12'h100, SPUR,          4'd8},  // R8 not normal
    {OP_RD,  12'h104, 32'hA000_0000, 4'd8},  // R8 fast vector
    {OP_PIN, 12'h000, 32'h0,         4'd8},  // R8
    {OP_RD,  12'h10C, 32'h12,        4'd8},  // R8 latch cleared
    {OP_RD,  12'h104, SPUR,          4'd9},  // R9
    {OP_RD,  12'h008, 32'h15,        4'd11}, // R11 readback
    {OP_WR,  12'h134, 32'h0BAD,      4'd9},  // R9 new spurious
    {OP_RD,  12'h100, 32'h0BAD,      4'd9}   // R9
  };

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input int req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input int req);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk); bus_sel = 1'b0;
    check(bus_rdata, exp, req);
  endtask

  task automatic check_pins(input logic [1:0] exp, input int req);
    repeat (2) @(negedge clk);
    check({30'd0, fiq_o, irq_o}, {30'd0, exp}, req);
  endtask

  task automatic drive_src(input logic [31:0] v);
    @(negedge clk); src_i = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) do_write(12'h080 + 12'(4 * i), vec_of(i));
    do_write(12'h000, 32'h10);   // line 0 edge
    do_write(12'h004, 32'h02);   // line 1 level prio 2
    do_write(12'h008, 32'h15);   // line 2 edge prio 5
    do_write(12'h00C, 32'h15);   // line 3 edge prio 5
    do_write(12'h010, 32'h02);   // line 4 level prio 2

    for (int k = 0; k < NV; k++) begin
      logic [49:0] e;
      e = TBL[k];
      case (e[49:48])
        OP_WR:  do_write(e[47:36], e[35:4]);
        OP_RD:  do_read(e[47:36], e[35:4], int'(e[3:0]));
        OP_PIN: check_pins(e[5:4], int'(e[3:0]));
        default: drive_src(e[35:4]);
      endcase
    end

    // R11: unused bits of a configuration word read as zero
    do_write(12'h01C, 32'hFFFF_FFFF);
    do_read(12'h01C, 32'h17, 11);

    // R1: reset mid-run restores defaults
    drive_src(32'h0);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    do_read(12'h110, 32'h0, 1);
    do_read(12'h10C, 32'h0, 1);
    do_read(12'h108, 32'h0, 1);
    check_pins(2'b00, 1);
    do_read(12'h100, SPUR, 9);   // R9 spurious value back to default

    // R7: eight nested levels, then unwind
    for (int k = 0; k < 8; k++) do_write(12'h000 + 12'(4 * (8 + k)), 32'h10 | 32'(k));
    do_write(12'h120, 32'h0000_FF00);
    for (int k = 0; k < 8; k++) begin
      do_write(12'h128, 32'h1 << (8 + k));
      do_read(12'h100, vec_of(8 + k), 7);
    end
    do_write(12'h128, 32'h100);
    do_read(12'h100, SPUR, 7);   // R7 level 0 blocked at full depth
    for (int k = 0; k < 7; k++) do_write(12'h130, 32'h0);
    check_pins(2'b00, 7);        // one level 0 still in service
    do_write(12'h130, 32'h0);
    check_pins(2'b01, 7);
    do_read(12'h100, vec_of(8), 7);
    do_read(12'h108, 32'd8, 5);  // R5

    finish_run();
  end
endmodule